// File: doc/BRIEF.md
# Timer External Trigger Slave Controller

This block sits between the trigger inputs of a general-purpose timer and the timer's counter. It conditions one asynchronous external trigger pin. The pin passes through a two-flop synchronizer, a polarity selection, a consecutive-sample digital filter and an edge prescaler. The block then turns the conditioned trigger, or one of several internal trigger sources, into four counter controls. These are a count tick, a one-cycle counter clear, a counter gate level and a sticky counter start.

Two external clocking schemes are provided. In the first, the slave mode field is set to its clock code and the counter advances on rising edges of the selected trigger. In the second, a separate enable advances the counter on prescaled edges of the filtered external trigger. The second scheme can run alongside the restart, pause and event slave modes. If both schemes are enabled, the filtered external trigger is the clock source. Selecting the filtered external trigger as the slave trigger while the second scheme is combined with a slave mode is an illegal configuration. The block flags it and blocks every slave action.

A state machine tracks the slave behaviour. It has six states. ST_OFF covers no slave action, including the internal-clock and mode-field clock cases. ST_RESTART, ST_PAUSE and ST_EVT_WAIT are entered from any state when the configuration selects restart, pause or event. ST_EVT_WAIT moves to ST_EVT_RUN on an active trigger edge. ST_EVT_RUN is held while event mode stays selected. ST_BLOCK is entered whenever the illegal configuration is present. A change of configuration moves the machine to the matching state on the next clock.

Top module: `tsc_trig_slave`

## Requirements
- R1: `cfg_pol` = 0 treats a high pin level as active, so a rising pin edge is the active edge. `cfg_pol` = 1 treats a low level as active, so a falling pin edge is the active edge. An inactive-going edge produces no tick.
- R2: A pin step is seen as a tick after it has been sampled for a fixed number of clock edges. With `cfg_flt` 0 or 1, the tick is visible after the 3rd rising clock edge that samples the new pin value. With `cfg_flt` = N ≥ 2, it is visible after the (N+2)th edge.
- R3: With `cfg_flt` = N > 0, the filtered level changes only after N consecutive synchronized samples differ from it. A pulse shorter than N cycles produces no tick.
- R4: `cfg_psc` codes 0, 1, 2 and 3 pass one of every 1, 2, 4 and 8 active filtered edges, counted from reset.
- R5: With `cfg_ext1_en` = 1, `cnt_tick` pulses for exactly one cycle per passed edge. With `cfg_ext1_en` = 0 and `cfg_mode` not 7, `cnt_tick` is held at 1.
- R6: With `cfg_mode` = 7 and `cfg_ext1_en` = 0, `cnt_tick` pulses once per rising edge of the selected trigger. If `cfg_ext1_en` = 1 as well, only filtered external trigger edges tick.
- R7: `cfg_mode` = 4 (restart) pulses `cnt_clr` for one cycle per active edge of the selected trigger. `cnt_clr` stays low in every other mode.
- R8: `cfg_mode` = 5 (pause) drives `cnt_gate` with the selected trigger level. In every other mode `cnt_gate` is 1.
- R9: `cfg_mode` = 6 (event) holds `cnt_start` low until the first active trigger edge. After that edge, `cnt_start` stays high while event mode remains selected.
- R10: `cfg_ext1_en` = 1 together with `cfg_mode` 4, 5 or 6 and `cfg_trgsel` = 7 raises `cfg_err`. It also suppresses `cnt_clr` and `cnt_start` and holds `cnt_gate` at 1. External ticks continue.
- R11: `cfg_sync_dly` = 1 delays the trigger edge used by the slave modes by one clock. A restart clear then appears one cycle later than with `cfg_sync_dly` = 0.
- R12: `cfg_trgsel` codes 0 to 3 select `itrg[0]` to `itrg[3]`, each registered once before use. Code 7 selects the filtered external trigger, using its prescaled edge and its level. Codes 4 to 6 select a source that is never active.
- R13: After reset with all configuration at zero, the outputs are `cnt_tick` = 1, `cnt_clr` = 0, `cnt_gate` = 1, `cnt_start` = 0 and `cfg_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pol | input | 1 | External trigger polarity: 0 high/rising active, 1 low/falling active |
| cfg_ext1_en | input | 1 | Enable for counting on prescaled filtered external trigger edges |
| cfg_psc | input | 2 | External edge prescaler code (divide by 1, 2, 4, 8) |
| cfg_flt | input | 4 | Filter length in consecutive samples (0 means none) |
| cfg_sync_dly | input | 1 | Delay slave trigger edges by one clock |
| cfg_trgsel | input | 3 | Slave trigger source select |
| cfg_mode | input | 3 | Slave mode: 4 restart, 5 pause, 6 event, 7 clock on trigger, others off |
| eti_pin | input | 1 | Raw asynchronous external trigger pin |
| itrg | input | 4 | Internal trigger sources, synchronous to clk |
| cnt_tick | output | 1 | Counter advance enable |
| cnt_clr | output | 1 | One-cycle counter clear |
| cnt_gate | output | 1 | Counter gate level |
| cnt_start | output | 1 | Sticky counter start |
| cfg_err | output | 1 | Illegal trigger select flag |

## Verification
The filtered external trigger can feed both the count tick and a slave action in the same cycle. This happens when source 7 is selected with a slave mode. The bench provokes it twice, using the same pin pulse train each time. In the legal case the external clock enable is off, and every filtered edge must produce a clear. In the illegal case the enable is on, and every edge must produce a tick while clear and start stay silent. The bench judges each case by counting ticks and clears over the same window and comparing the counts with the number of pulses driven.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    localparam int SEL_W  = 3;
    localparam int MODE_W = 3;

    localparam logic [MODE_W-1:0] MODE_RESTART = 3'd4;
    localparam logic [MODE_W-1:0] MODE_PAUSE   = 3'd5;
    localparam logic [MODE_W-1:0] MODE_EVENT   = 3'd6;
    localparam logic [MODE_W-1:0] MODE_EXTCLK  = 3'd7;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_RESTART,
        ST_PAUSE,
        ST_EVT_WAIT,
        ST_EVT_RUN,
        ST_BLOCK
    } tsc_state_e;
endpackage

// File: rtl/tsc_cond.sv
// Pin conditioning: synchronizer, polarity, consecutive-sample filter, edge detect.
module tsc_cond #(
    parameter int FLT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin,
    input  logic             pol,
    input  logic [FLT_W-1:0] flt,
    output logic             lvl_out,
    output logic             rise
);
    localparam logic [FLT_W:0] ONE_F = {{FLT_W{1'b0}}, 1'b1};

    logic             s1, s2;
    logic             lvl;
    logic             filt_q, filt_d;
    logic [FLT_W-1:0] fcnt;
    logic [FLT_W:0]   fnext;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
        end else begin
            s1 <= pin;
            s2 <= s1;
        end
    end

    assign lvl   = s2 ^ pol;
    assign fnext = {1'b0, fcnt} + ONE_F;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_q <= 1'b0;
            fcnt   <= '0;
        end else if (lvl == filt_q) begin
            fcnt <= '0;
        end else if (flt == '0 || fnext >= {1'b0, flt}) begin
            filt_q <= lvl;
            fcnt   <= '0;
        end else begin
            fcnt <= fnext[FLT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) filt_d <= 1'b0;
        else        filt_d <= filt_q;
    end

    assign lvl_out = filt_q;
    assign rise    = filt_q & ~filt_d;
endmodule

// File: rtl/tsc_presc.sv
// Passes one of every 2**psc input edges.
module tsc_presc #(
    parameter int PSC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic [PSC_W-1:0] psc,
    output logic             pulse
);
    localparam int PCNT_W = (1 << PSC_W) - 1;

    logic [PCNT_W-1:0] pcnt;
    logic [PCNT_W-1:0] lim;

    always_comb begin
        lim = '0;
        for (int i = 0; i < PCNT_W; i++) begin
            if (i < int'(psc)) lim[i] = 1'b1;
        end
    end

    assign pulse = rise && (pcnt >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     pcnt <= '0;
        else if (pulse) pcnt <= '0;
        else if (rise)  pcnt <= pcnt + 1'b1;
    end
endmodule

// File: rtl/tsc_trgsel.sv
// Slave trigger source multiplexer with registered internal triggers.
module tsc_trgsel
    import tsc_pkg::*;
#(
    parameter int NUM_ITRG = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_ITRG-1:0] itrg,
    input  logic [SEL_W-1:0]    sel,
    input  logic                etif_lvl,
    input  logic                etif_pulse,
    output logic                trg_lvl,
    output logic                trg_edge
);
    logic [NUM_ITRG-1:0] itrg_q, itrg_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            itrg_q <= '0;
            itrg_d <= '0;
        end else begin
            itrg_q <= itrg;
            itrg_d <= itrg_q;
        end
    end

    always_comb begin
        trg_lvl  = 1'b0;
        trg_edge = 1'b0;
        if (sel == {SEL_W{1'b1}}) begin
            trg_lvl  = etif_lvl;
            trg_edge = etif_pulse;
        end else begin
            for (int i = 0; i < NUM_ITRG; i++) begin
                if (sel == SEL_W'(i)) begin
                    trg_lvl  = itrg_q[i];
                    trg_edge = itrg_q[i] & ~itrg_d[i];
                end
            end
        end
    end
endmodule

// File: rtl/tsc_slave_fsm.sv
// Slave mode state machine and counter control outputs.
module tsc_slave_fsm
    import tsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic [SEL_W-1:0]  sel,
    input  logic              ext1_en,
    input  logic              sync_dly,
    input  logic              trg_lvl,
    input  logic              trg_edge,
    input  logic              etif_pulse,
    output logic              cnt_tick,
    output logic              cnt_clr,
    output logic              cnt_gate,
    output logic              cnt_start,
    output logic              cfg_err
);
    tsc_state_e state, state_nx;
    logic       edge_d;
    logic       act_edge;
    logic       slave_mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) edge_d <= 1'b0;
        else        edge_d <= trg_edge;
    end

    assign act_edge   = sync_dly ? edge_d : trg_edge;
    assign slave_mode = (mode == MODE_RESTART) || (mode == MODE_PAUSE) || (mode == MODE_EVENT);
    assign cfg_err    = ext1_en && slave_mode && (sel == {SEL_W{1'b1}});

    // Counter clock source: filtered external edges win over the mode-field clock.
    always_comb begin
        if (ext1_en)                  cnt_tick = etif_pulse;
        else if (mode == MODE_EXTCLK) cnt_tick = trg_edge;
        else                          cnt_tick = 1'b1;
    end

    always_comb begin
        state_nx = ST_OFF;
        if (cfg_err) begin
            state_nx = ST_BLOCK;
        end else begin
            unique case (mode)
                MODE_RESTART: state_nx = ST_RESTART;
                MODE_PAUSE:   state_nx = ST_PAUSE;
                MODE_EVENT: begin
                    if (state == ST_EVT_RUN || (state == ST_EVT_WAIT && act_edge))
                        state_nx = ST_EVT_RUN;
                    else
                        state_nx = ST_EVT_WAIT;
                end
                default:      state_nx = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        cnt_clr   = 1'b0;
        cnt_gate  = 1'b1;
        cnt_start = 1'b0;
        unique case (state)
            ST_RESTART: cnt_clr   = act_edge;
            ST_PAUSE:   cnt_gate  = trg_lvl;
            ST_EVT_RUN: cnt_start = 1'b1;
            default:    ;
        endcase
    end
endmodule

// File: rtl/tsc_trig_slave.sv
module tsc_trig_slave
    import tsc_pkg::*;
#(
    parameter int NUM_ITRG = 4,
    parameter int FLT_W    = 4,
    parameter int PSC_W    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_pol,
    input  logic                cfg_ext1_en,
    input  logic [PSC_W-1:0]    cfg_psc,
    input  logic [FLT_W-1:0]    cfg_flt,
    input  logic                cfg_sync_dly,
    input  logic [SEL_W-1:0]    cfg_trgsel,
    input  logic [MODE_W-1:0]   cfg_mode,
    input  logic                eti_pin,
    input  logic [NUM_ITRG-1:0] itrg,
    output logic                cnt_tick,
    output logic                cnt_clr,
    output logic                cnt_gate,
    output logic                cnt_start,
    output logic                cfg_err
);
    logic etif_lvl, etif_rise, etif_pulse;
    logic trg_lvl, trg_edge;

    tsc_cond #(.FLT_W(FLT_W)) u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     (eti_pin),
        .pol     (cfg_pol),
        .flt     (cfg_flt),
        .lvl_out (etif_lvl),
        .rise    (etif_rise)
    );

    tsc_presc #(.PSC_W(PSC_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .rise  (etif_rise),
        .psc   (cfg_psc),
        .pulse (etif_pulse)
    );

    tsc_trgsel #(.NUM_ITRG(NUM_ITRG)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .itrg       (itrg),
        .sel        (cfg_trgsel),
        .etif_lvl   (etif_lvl),
        .etif_pulse (etif_pulse),
        .trg_lvl    (trg_lvl),
        .trg_edge   (trg_edge)
    );

    tsc_slave_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (cfg_mode),
        .sel        (cfg_trgsel),
        .ext1_en    (cfg_ext1_en),
        .sync_dly   (cfg_sync_dly),
        .trg_lvl    (trg_lvl),
        .trg_edge   (trg_edge),
        .etif_pulse (etif_pulse),
        .cnt_tick   (cnt_tick),
        .cnt_clr    (cnt_clr),
        .cnt_gate   (cnt_gate),
        .cnt_start  (cnt_start),
        .cfg_err    (cfg_err)
    );
endmodule

// File: rtl/tsc_trig_slave_chk.sv
module tsc_trig_slave_chk
    import tsc_pkg::*;
#(
    parameter int NUM_ITRG = 4,
    parameter int FLT_W    = 4,
    parameter int PSC_W    = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_pol,
    input logic                cfg_ext1_en,
    input logic [PSC_W-1:0]    cfg_psc,
    input logic [FLT_W-1:0]    cfg_flt,
    input logic                cfg_sync_dly,
    input logic [SEL_W-1:0]    cfg_trgsel,
    input logic [MODE_W-1:0]   cfg_mode,
    input logic                eti_pin,
    input logic [NUM_ITRG-1:0] itrg,
    input logic                cnt_tick,
    input logic                cnt_clr,
    input logic                cnt_gate,
    input logic                cnt_start,
    input logic                cfg_err
);
    assert_clr_only_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |-> ($past(cfg_mode) == MODE_RESTART));

    assert_clr_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (!cnt_clr || !$stable(cfg_sync_dly)));

    assert_gate_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_mode) != MODE_PAUSE) |-> cnt_gate);

    assert_start_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_start && cfg_mode == MODE_EVENT && !cfg_err) |=> cnt_start);

    assert_err_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_err) |-> (!cnt_clr && !cnt_start && cnt_gate));

    assert_tick_sparse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ext1_en && cnt_tick) |=> (!cnt_tick || !cfg_ext1_en));
endmodule

bind tsc_trig_slave tsc_trig_slave_chk #(
    .NUM_ITRG (NUM_ITRG),
    .FLT_W    (FLT_W),
    .PSC_W    (PSC_W)
) u_chk (.*);

// File: tb/sim_tsc_trig_slave.sv
`timescale 1ns/1ps
module sim_tsc_trig_slave;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_pol = 1'b0;
    logic       cfg_ext1_en = 1'b0;
    logic [1:0] cfg_psc = '0;
    logic [3:0] cfg_flt = '0;
    logic       cfg_sync_dly = 1'b0;
    logic [2:0] cfg_trgsel = '0;
    logic [2:0] cfg_mode = '0;
    logic       eti_pin = 1'b0;
    logic [3:0] itrg = '0;
    logic       cnt_tick, cnt_clr, cnt_gate, cnt_start, cfg_err;

    int checks = 0;
    int failures = 0;
    int n_tick = 0;
    int n_clr = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tsc_trig_slave u0 (
        .clk(clk), .rst_n(rst_n), .cfg_pol(cfg_pol), .cfg_ext1_en(cfg_ext1_en),
        .cfg_psc(cfg_psc), .cfg_flt(cfg_flt), .cfg_sync_dly(cfg_sync_dly),
        .cfg_trgsel(cfg_trgsel), .cfg_mode(cfg_mode), .eti_pin(eti_pin), .itrg(itrg),
        .cnt_tick(cnt_tick), .cnt_clr(cnt_clr), .cnt_gate(cnt_gate),
        .cnt_start(cnt_start), .cfg_err(cfg_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: wait for the falling edge, then tally outputs.
    task automatic cyc();
        @(negedge clk);
        if (cnt_tick) n_tick++;
        if (cnt_clr)  n_clr++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
        n_tick = 0;
        n_clr = 0;
    endtask

    task automatic set_cfg(input bit pol, input bit e1, input int psc, input int flt,
                           input bit sd, input int sel, input int mode, input bit pin_idle);
        cfg_pol = pol; cfg_ext1_en = e1; cfg_psc = 2'(psc); cfg_flt = 4'(flt);
        cfg_sync_dly = sd; cfg_trgsel = 3'(sel); cfg_mode = 3'(mode);
        eti_pin = pin_idle; itrg = '0;
    endtask

    task automatic pin_pulses(input int n, input bit active, input int hi, input int lo);
        for (int i = 0; i < n; i++) begin
            eti_pin = active;  idle(hi);
            eti_pin = ~active; idle(lo);
        end
    endtask

    task automatic itrg_pulses(input int bitn, input int n);
        for (int i = 0; i < n; i++) begin
            itrg[bitn] = 1'b1; idle(2);
            itrg[bitn] = 1'b0; idle(2);
        end
    endtask

    task automatic t_reset_state();
        set_cfg(0, 0, 0, 0, 0, 0, 0, 0);
        do_reset();
        check(cnt_tick == 1'b1, "R13 tick", cnt_tick, 1);
        check(cnt_clr == 1'b0, "R13 clr", cnt_clr, 0);
        check(cnt_gate == 1'b1, "R13 gate", cnt_gate, 1);
        check(cnt_start == 1'b0, "R13 start", cnt_start, 0);
        check(cfg_err == 1'b0, "R13 err", cfg_err, 0);
    endtask

    task automatic t_latency(input int flt);
        int n;
        int exp;
        set_cfg(0, 1, 0, flt, 0, 0, 0, 0);
        do_reset();
        idle(4);
        check(n_tick == 0, "R5 no tick while idle", n_tick, 0);
        eti_pin = 1'b1;
        n = 0;
        for (int i = 0; i < 40; i++) begin
            cyc();
            n++;
            if (cnt_tick) break;
        end
        exp = (flt <= 1) ? 3 : flt + 2;
        check(n == exp, "R2 pin to tick latency", n, exp);
        idle(flt + 4);
    endtask

    task automatic t_polarity();
        set_cfg(1, 1, 0, 0, 0, 0, 0, 1);
        do_reset();
        idle(4);
        eti_pin = 1'b0; idle(6);
        check(n_tick == 1, "R1 falling edge active when inverted", n_tick, 1);
        n_tick = 0;
        eti_pin = 1'b1; idle(8);
        check(n_tick == 0, "R1 rising edge inactive when inverted", n_tick, 0);
    endtask

    task automatic t_filter();
        set_cfg(0, 1, 0, 4, 0, 0, 0, 0);
        do_reset();
        idle(3);
        pin_pulses(1, 1'b1, 3, 12);
        check(n_tick == 0, "R3 short pulse rejected", n_tick, 0);
        pin_pulses(1, 1'b1, 6, 12);
        check(n_tick == 1, "R3 long pulse accepted", n_tick, 1);
    endtask

    task automatic t_presc(input int psc);
        int exp;
        set_cfg(0, 1, psc, 0, 0, 0, 0, 0);
        do_reset();
        idle(3);
        pin_pulses(16, 1'b1, 2, 2);
        idle(6);
        exp = 16 >> psc;
        check(n_tick == exp, "R4 prescaler division", n_tick, exp);
    endtask

    task automatic t_mode_clock();
        set_cfg(0, 0, 0, 0, 0, 1, 7, 0);
        do_reset();
        idle(2);
        itrg_pulses(1, 5);
        idle(3);
        check(n_tick == 5, "R6 mode-field clock on trigger edges", n_tick, 5);
        cfg_ext1_en = 1'b1;
        idle(3);
        n_tick = 0;
        itrg_pulses(1, 3);
        idle(3);
        check(n_tick == 0, "R6 external clock wins, internal edges ignored", n_tick, 0);
        pin_pulses(2, 1'b1, 3, 3);
        idle(4);
        check(n_tick == 2, "R6 external clock wins, pin edges count", n_tick, 2);
    endtask

    task automatic t_restart(input bit sd);
        int n;
        int exp;
        set_cfg(0, 0, 0, 0, sd, 2, 4, 0);
        do_reset();
        idle(3);
        itrg[2] = 1'b1;
        n = 0;
        for (int i = 0; i < 8; i++) begin
            cyc();
            n++;
            if (cnt_clr) break;
        end
        exp = sd ? 2 : 1;
        check(n == exp, sd ? "R11 delayed clear latency" : "R7 clear latency", n, exp);
        idle(4);
        itrg[2] = 1'b0;
        idle(3);
        check(n_clr == 1, "R7 one clear cycle per edge", n_clr, 1);
        n_clr = 0;
        itrg_pulses(2, 4);
        idle(3);
        check(n_clr == 4, "R7 clear count", n_clr, 4);
    endtask

    task automatic t_pause();
        set_cfg(0, 0, 0, 0, 0, 0, 5, 0);
        do_reset();
        itrg[0] = 1'b1; idle(3);
        check(cnt_gate == 1'b1, "R8 gate open with trigger high", cnt_gate, 1);
        itrg[0] = 1'b0; idle(3);
        check(cnt_gate == 1'b0, "R8 gate closed with trigger low", cnt_gate, 0);
        itrg[0] = 1'b1; idle(3);
        check(cnt_gate == 1'b1, "R8 gate reopens", cnt_gate, 1);
    endtask

    task automatic t_event();
        set_cfg(0, 0, 0, 0, 0, 3, 6, 0);
        do_reset();
        idle(4);
        check(cnt_start == 1'b0, "R9 start low before edge", cnt_start, 0);
        itrg_pulses(3, 1);
        idle(3);
        check(cnt_start == 1'b1, "R9 start after edge", cnt_start, 1);
        idle(20);
        check(cnt_start == 1'b1, "R9 start sticky", cnt_start, 1);
        cfg_mode = 3'd0; idle(2);
        check(cnt_start == 1'b0, "R9 start drops when mode left", cnt_start, 0);
    endtask

    task automatic t_illegal();
        // Legal reference: same source, external clock enable off.
        set_cfg(0, 0, 0, 0, 0, 7, 4, 0);
        do_reset();
        idle(2);
        check(cfg_err == 1'b0, "R10 no flag when legal", cfg_err, 0);
        pin_pulses(3, 1'b1, 3, 3);
        idle(4);
        check(n_clr == 3, "R12 source 7 restarts on pin edges", n_clr, 3);
        // Illegal combination.
        set_cfg(0, 1, 0, 0, 0, 7, 4, 0);
        do_reset();
        idle(2);
        check(cfg_err == 1'b1, "R10 flag raised", cfg_err, 1);
        pin_pulses(3, 1'b1, 3, 3);
        idle(4);
        check(n_clr == 0, "R10 clear suppressed", n_clr, 0);
        check(n_tick == 3, "R10 ticks continue", n_tick, 3);
        cfg_mode = 3'd6; idle(2);
        pin_pulses(2, 1'b1, 3, 3);
        idle(3);
        check(cnt_start == 1'b0, "R10 start suppressed", cnt_start, 0);
        cfg_mode = 3'd5; idle(3);
        check(cnt_gate == 1'b1, "R10 gate held open", cnt_gate, 1);
    endtask

    task automatic t_select();
        set_cfg(0, 0, 0, 0, 0, 5, 4, 0);
        do_reset();
        idle(2);
        for (int b = 0; b < 4; b++) itrg_pulses(b, 1);
        pin_pulses(2, 1'b1, 3, 3);
        idle(3);
        check(n_clr == 0, "R12 codes 4..6 never active", n_clr, 0);
        cfg_trgsel = 3'd0; idle(2);
        n_clr = 0;
        itrg_pulses(1, 2);
        idle(2);
        check(n_clr == 0, "R12 unselected source ignored", n_clr, 0);
        itrg_pulses(0, 2);
        idle(2);
        check(n_clr == 2, "R12 selected source used", n_clr, 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_latency(0);
        t_latency(1);
        t_latency(5);
        t_polarity();
        t_filter();
        for (int p = 0; p < 4; p++) t_presc(p);
        t_mode_clock();
        t_restart(1'b0);
        t_restart(1'b1);
        t_pause();
        t_event();
        t_illegal();
        t_select();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule